// File: doc/BRIEF.md
# Parallel Port Extended Mode Controller

This block holds the extended control register of a bidirectional parallel port and the byte FIFO that the register governs. A host reaches it through a small register window with single-cycle write and read strobes. The mode field in the control register sets how the FIFO behaves. The FIFO can be held empty, sent to the port with the standard protocol, filled from both address and data writes in ECP forward mode, filled from incoming port bytes in ECP reverse mode, or used only as a loop-back for the host.

The block also drives the port data lines and their output enable. It turns falling edges of the fault line into one-cycle interrupt pulses, and it gives a DMA enable and a DMA request that follow the FIFO state. Two configuration registers are visible only in configuration mode. The cable handshake timing and the DMA controller sit outside the block. The port side sees a plain valid/ready byte stream (`drain_valid`/`drain_rdy`) and an incoming byte strobe (`rx_valid`).

Top module: `pp_ext_ctrl`

## Requirements
- R1: After reset the control register (offset 3) reads 0x11: mode 000, fault-inhibit bit 4 = 1, DMA bit 3 = 0, service bit 2 = 0, full bit 1 = 0, empty bit 0 = 1. `fault_irq`, `dma_en` and `dma_req` are 0.
- R2: Offset 3 is the control register. Bits 7:5 are the mode (000 standard, 001 bidirectional, 010 FIFO, 011 ECP, 100 EPP, 101 reserved, 110 test, 111 configuration). Bits 4, 3 and 2 are read/write. Bits 1 (full) and 0 (empty) are read-only, and writes to them are ignored.
- R3: In mode 000 the FIFO is held empty. Writing mode 000 empties it by the next cycle, and data writes in that mode are dropped.
- R4: A read of offset 0 returns `pin_in` in mode 001 and the last byte written to offset 0 in any other mode. `pd_out` is that latched byte. `pd_oe` is 0 when `port_dir` = 1 in mode 001 or 011, and 1 in all other cases.
- R5: In mode 010 a write to offset 1 queues a byte. With `port_dir` = 0 the head byte is presented on `drain_data` with `drain_valid`, and it is removed on a cycle with `drain_rdy`. With `port_dir` = 1 nothing drains.
- R6: In mode 011 with `port_dir` = 0, writes to offset 1 (data, tag 0) and to offset 2 (address, tag 1) enter one FIFO in arrival order. Each byte drains with its tag on `drain_tag`. Offset 2 writes in other modes are dropped.
- R7: In mode 011 with `port_dir` = 1, each `rx_valid` cycle queues `rx_data` with tag 0. A read of offset 1 returns the head byte and removes it. Host writes to offset 1 are dropped.
- R8: In mode 110 the host writes offset 1 to queue a byte and reads offset 1 to take the head byte. `drain_valid` stays 0.
- R9: In mode 111, offsets 4 and 5 are two read/write configuration bytes. In other modes they read 0 and writes to them are ignored.
- R10: When bit 4 is 0, `fault_irq` is high for exactly one cycle, in the cycle after the first clock edge that samples `fault_n` low following a high sample. When bit 4 is 1, falling edges raise nothing.
- R11: A write that changes bit 4 from 1 to 0 while `fault_n` is low raises a one-cycle `fault_irq` in the following cycle.
- R12: `dma_en` equals bit 3. `dma_req` is 1 when bit 3 is set and either (the FIFO drains forward and is not full) or (the mode is ECP reverse and the FIFO is not empty). Otherwise it is 0.
- R13: The FIFO holds 16 bytes. Bit 1 reads 1 at 16 entries, and pushes while full are dropped. A read of offset 1 while empty returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the FIFO on offset 1) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from offset and state |
| port_dir | input | 1 | Port direction, 1 = reverse |
| pin_in | input | 8 | Sampled data-line value |
| pd_out | output | 8 | Data-line drive value |
| pd_oe | output | 1 | Data-line output enable |
| rx_valid | input | 1 | Incoming port byte strobe |
| rx_data | input | 8 | Incoming port byte |
| drain_rdy | input | 1 | Port accepts the head byte |
| drain_valid | output | 1 | Head byte offered to the port |
| drain_data | output | 8 | Head byte |
| drain_tag | output | 1 | Head byte tag, 1 = address |
| fault_n | input | 1 | Fault line, active low |
| fault_irq | output | 1 | One-cycle fault interrupt pulse |
| dma_en | output | 1 | DMA enable |
| dma_req | output | 1 | DMA request |

## Verification
A register write or FIFO push clocked at one edge shows up on `host_rdata`, the flags and the drain outputs from that edge onward. Data reads and the output enable follow `pin_in` and `port_dir` in the same cycle. The fault pulse comes one cycle after the edge that samples the fall or the enable-clearing write. The bench changes inputs just after the falling clock edge and compares every output against a behavioural queue model at the next falling edge. The model is advanced at each rising edge from the same inputs, so each result is checked in the first cycle it is due and in every cycle after that.

// File: rtl/pp_ext_ctrl.sv
module pp_ext_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       port_dir,
  input  logic [7:0] pin_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       drain_rdy,
  output logic       drain_valid,
  output logic [7:0] drain_data,
  output logic       drain_tag,
  input  logic       fault_n,
  output logic       fault_irq,
  output logic       dma_en,
  output logic       dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [2:0]    mode;
  logic          ien_n, dma_on, svc;
  logic [7:0]    latch, cfg_a, cfg_b;
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          fault_q, irq_q;

  wire full    = cnt == CW'(DEPTH);
  wire empty   = cnt == '0;
  wire fwd     = (mode == 3'b010 || mode == 3'b011) && !port_dir;
  wire ecp_rev = mode == 3'b011 && port_dir;
  wire m_test  = mode == 3'b110;
  wire m_cfg   = mode == 3'b111;
  wire ctrl_wr = host_wr && host_addr == 3'd3;
  wire clr     = mode == 3'b000 || (ctrl_wr && host_wdata[7:5] == 3'b000);

  wire push_d = host_wr && host_addr == 3'd1 &&
                (m_test || mode == 3'b010 || (mode == 3'b011 && !port_dir));
  wire push_a = host_wr && host_addr == 3'd2 && mode == 3'b011 && !port_dir;
  wire push_r = ecp_rev && rx_valid;
  wire push   = (push_d || push_a || push_r) && !full;
  wire [8:0] push_word = {push_a, push_r ? rx_data : host_wdata};

  wire host_pop_ok = m_test || ecp_rev;
  wire pop_host  = host_rd && host_addr == 3'd1 && host_pop_ok && !empty;
  wire pop_drain = fwd && !empty && drain_rdy;
  wire pop       = pop_host || pop_drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 3'b000; ien_n <= 1'b1; dma_on <= 1'b0; svc <= 1'b0;
      latch <= '0; cfg_a <= '0; cfg_b <= '0;
      fault_q <= 1'b1; irq_q <= 1'b0;
    end else begin
      if (ctrl_wr) {mode, ien_n, dma_on, svc} <= host_wdata[7:2];
      if (host_wr && host_addr == 3'd0) latch <= host_wdata;
      if (host_wr && host_addr == 3'd4 && m_cfg) cfg_a <= host_wdata;
      if (host_wr && host_addr == 3'd5 && m_cfg) cfg_b <= host_wdata;
      fault_q <= fault_n;
      irq_q   <= (!ien_n && fault_q && !fault_n) ||
                 (ctrl_wr && ien_n && !host_wdata[4] && !fault_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push && !clr) mem[wp] <= push_word;

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = (mode == 3'b001) ? pin_in : latch;
      3'd1:    host_rdata = (host_pop_ok && !empty) ? mem[rp][7:0] : 8'h00;
      3'd3:    host_rdata = {mode, ien_n, dma_on, svc, full, empty};
      3'd4:    host_rdata = m_cfg ? cfg_a : 8'h00;
      3'd5:    host_rdata = m_cfg ? cfg_b : 8'h00;
      default: host_rdata = 8'h00;
    endcase
  end

  assign pd_out      = latch;
  assign pd_oe       = !((mode == 3'b001 || mode == 3'b011) && port_dir);
  assign drain_valid = fwd && !empty;
  assign drain_data  = mem[rp][7:0];
  assign drain_tag   = mem[rp][8];
  assign fault_irq   = irq_q;
  assign dma_en      = dma_on;
  assign dma_req     = dma_on && ((fwd && !full) || (ecp_rev && !empty));
endmodule

// File: rtl/pp_ext_ctrl_chk.sv
module pp_ext_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [CW-1:0] cnt,
  input logic          ien_n,
  input logic          fault_irq,
  input logic          dma_en,
  input logic          dma_req,
  input logic          drain_valid
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R13
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) mode == 3'b000 |=> cnt == '0); // R3
  AST_TEST_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) mode == 3'b110 |-> !drain_valid); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fault_irq |=> !fault_irq); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) ($past(ien_n) && ien_n) |-> !fault_irq); // R10
  AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n) !dma_en |-> !dma_req); // R12
endmodule

bind pp_ext_ctrl pp_ext_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cnt(cnt), .ien_n(ien_n),
  .fault_irq(fault_irq), .dma_en(dma_en), .dma_req(dma_req),
  .drain_valid(drain_valid)
);

// File: tb/pp_ext_ctrl_bench.sv
module pp_ext_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, port_dir = 0, rx_valid = 0, drain_rdy = 0, fault_n = 1;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, pin_in = 0, rx_data = 0;
  logic [7:0] host_rdata, pd_out, drain_data;
  logic pd_oe, drain_valid, drain_tag, fault_irq, dma_en, dma_req;

  pp_ext_ctrl u_pp_ext_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  int m_mode = 0;
  bit m_ien_n = 1, m_dma = 0, m_svc = 0, m_fq = 1, m_irq = 0;
  logic [7:0] m_latch = 0, m_cfga = 0, m_cfgb = 0;
  logic [8:0] q[$];

  function automatic bit m_fwd(); return (m_mode == 2 || m_mode == 3) && !port_dir; endfunction
  function automatic bit m_rev(); return m_mode == 3 && port_dir; endfunction

  function automatic logic [7:0] exp_rdata();
    case (host_addr)
      0: return (m_mode == 1) ? pin_in : m_latch;
      1: return ((m_mode == 6 || m_rev()) && q.size() > 0) ? q[0][7:0] : 8'h00;
      3: return {m_mode[2:0], m_ien_n, m_dma, m_svc, q.size() == 16, q.size() == 0};
      4: return (m_mode == 7) ? m_cfga : 8'h00;
      5: return (m_mode == 7) ? m_cfgb : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    bit wrd, wra, wrr, dpush, dpop, nirq;
    wrd = host_wr && host_addr == 1 && (m_mode == 6 || m_mode == 2 || (m_mode == 3 && !port_dir));
    wra = host_wr && host_addr == 2 && m_mode == 3 && !port_dir;
    wrr = m_rev() && rx_valid;
    dpush = (wrd || wra || wrr) && q.size() < 16;
    dpop = q.size() > 0 && ((host_rd && host_addr == 1 && (m_mode == 6 || m_rev())) ||
                            (m_fwd() && drain_rdy));
    nirq = (!m_ien_n && m_fq && !fault_n) ||
           (host_wr && host_addr == 3 && m_ien_n && !host_wdata[4] && !fault_n);
    if (m_mode == 0 || (host_wr && host_addr == 3 && host_wdata[7:5] == 0)) q.delete();
    else begin
      if (dpop) void'(q.pop_front());
      if (dpush) q.push_back({wra, wrr ? rx_data : host_wdata});
    end
    if (host_wr && host_addr == 0) m_latch = host_wdata;
    if (host_wr && host_addr == 4 && m_mode == 7) m_cfga = host_wdata;
    if (host_wr && host_addr == 5 && m_mode == 7) m_cfgb = host_wdata;
    if (host_wr && host_addr == 3) begin
      m_mode = int'(host_wdata[7:5]); m_ien_n = host_wdata[4];
      m_dma = host_wdata[3]; m_svc = host_wdata[2];
    end
    m_fq = fault_n;
    m_irq = nirq;
  end

  always @(negedge clk) if (rst_n && !done) begin
    string rq;
    bit dv;
    case (host_addr)
      0: rq = "R4"; 1: rq = (m_mode == 6) ? "R8" : "R7"; 3: rq = "R2";
      4, 5: rq = "R9"; default: rq = "R6";
    endcase
    chk(rq, host_rdata, exp_rdata());
    chk("R10/R11 fault_irq", fault_irq, m_irq);
    chk("R12 dma_en", dma_en, m_dma);
    chk("R12 dma_req", dma_req, m_dma && ((m_fwd() && q.size() < 16) || (m_rev() && q.size() > 0)));
    dv = m_fwd() && q.size() > 0;
    chk("R5 drain_valid", drain_valid, dv);
    if (dv) chk("R6 drain head", {drain_tag, drain_data}, q[0]);
    chk("R4 pd_out", pd_out, m_latch);
    chk("R4 pd_oe", pd_oe, !((m_mode == 1 || m_mode == 3) && port_dir));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); host_wr = 0;
  endtask
  task automatic rd(logic [2:0] a);
    host_rd = 1; host_addr = a; tick(); host_rd = 0;
  endtask

  initial begin
    tick(3); rst_n = 1; host_addr = 3;
    @(negedge clk);
    chk("R1 reset ctrl", host_rdata, 8'h11);
    chk("R1 reset irq", fault_irq, 0);
    chk("R1 reset dma", {dma_en, dma_req}, 0);
    #1;
    // R2: read-only flag bits ignore writes, service bit is r/w
    wr(3, 8'h17); host_addr = 3; tick();
    // R8/R13: test mode fill past full, then drain by reads
    wr(3, 8'hD0);
    for (int i = 0; i < 18; i++) wr(1, 8'(8'h40 + i));
    host_addr = 3; tick();
    @(negedge clk); chk("R13 full flag", host_rdata[1:0], 2'b10); #1;
    for (int i = 0; i < 17; i++) rd(1);
    // R3: hold clear
    for (int i = 0; i < 3; i++) wr(1, 8'(i));
    wr(3, 8'h10); host_addr = 3; tick(); wr(1, 8'hAA); host_addr = 3; tick();
    // R5: FIFO mode forward and reverse with DMA
    wr(3, 8'h58); drain_rdy = 0;
    for (int i = 0; i < 3; i++) wr(1, 8'(8'h20 + i));
    drain_rdy = 1; tick(4); drain_rdy = 0;
    port_dir = 1; wr(1, 8'h77); drain_rdy = 1; tick(3); drain_rdy = 0; port_dir = 0;
    // R6: ECP forward merge
    wr(3, 8'h78);
    wr(1, 8'h01); wr(2, 8'hA2); wr(1, 8'h03); wr(2, 8'hA4);
    drain_rdy = 1; tick(6); drain_rdy = 0;
    wr(3, 8'h58); wr(2, 8'hEE); tick(2);
    // R7: ECP reverse
    wr(3, 8'h78); port_dir = 1; tick();
    for (int i = 0; i < 4; i++) begin rx_valid = 1; rx_data = 8'(8'hC0 + i); tick(); end
    rx_valid = 0; wr(1, 8'h55);
    for (int i = 0; i < 5; i++) rd(1);
    port_dir = 0;
    // R4: bidirectional mode
    wr(0, 8'h3C); wr(3, 8'h30); pin_in = 8'h96; host_addr = 0; tick(2);
    port_dir = 1; tick(2); port_dir = 0;
    wr(3, 8'h90); host_addr = 0; port_dir = 1; tick(2); port_dir = 0;
    // R9: configuration window
    wr(4, 8'h11); wr(5, 8'h22); host_addr = 4; tick();
    wr(3, 8'hF0); wr(4, 8'h5A); wr(5, 8'hA5); host_addr = 4; tick(); host_addr = 5; tick();
    wr(3, 8'hD0); host_addr = 4; tick(); host_addr = 5; tick();
    // R10: edge interrupt enabled, then masked
    wr(3, 8'hC0); fault_n = 0; tick(3); fault_n = 1; tick(2); fault_n = 0; tick(2); fault_n = 1; tick();
    wr(3, 8'hD0); fault_n = 0; tick(3);
    // R11: clear inhibit while fault low
    wr(3, 8'hC0); tick(3); fault_n = 1; tick(2);
    // R12: DMA request in reverse with data
    wr(3, 8'h78); port_dir = 1; rx_valid = 1; rx_data = 8'h9; tick(); rx_valid = 0; tick(2);
    rd(1); port_dir = 0; tick(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule